// File: doc/BRIEF.md
# Key-sequenced watchdog controller

This block guards a system against a hung processor. Software arms a 64-bit counter by writing two fixed 16-bit keys, in order, into one 32-bit control word. The first key (0xA5C6, accepted only once the enable bit is set) takes the controller from idle to a pre-armed state. The second key (0xDA7E) makes it active and starts the count from zero. Once active, the counter advances every clock. If it reaches the period supplied on `period_i`, the controller raises a reset request.

Software keeps the system alive by writing the same two keys again, first then second, which returns the counter to zero. While active, any key other than the two valid ones is treated as a runaway write and raises the reset request at once. Before the active state, such a key is ignored.

The reset request is sticky until the hardware reset clears the whole block. The controller only acts while the global timer mode selects the 64-bit watchdog mode and both counter halves are out of reset; otherwise it holds its state.

Top module: `wdog_key_ctrl`

## Requirements
- R1: After `rst_ni` is released, `rst_req_o` is 0, the controller is idle and the enable bit is clear.
- R2: In the control word, bit 14 is the enable bit (1 = enable) and bits [31:16] hold the key. Once written as 1, the enable bit stays set until the hardware reset.
- R3: From idle, a write with key 0xA5C6 moves to pre-armed only if the enable bit is set, either in that same write or earlier. Without it the controller stays idle.
- R4: From pre-armed, a write with key 0xDA7E makes the controller active with the counter at zero. The same key written while idle has no effect.
- R5: While active, the counter advances by one per clock. When it is at or above `period_i`, `rst_req_o` rises on the next edge. With a constant period P, `rst_req_o` is first high P+1 edges after the edge that took the arming write.
- R6: While active, a write of 0xA5C6 followed later by a write of 0xDA7E returns the counter to zero and the controller stays active. A lone 0xDA7E write while active has no effect.
- R7: While active, including between the two service keys, a write whose key is neither 0xA5C6 nor 0xDA7E raises `rst_req_o` on the edge that takes the write.
- R8: Before the active state, a write with an invalid key changes nothing: a pre-armed controller still accepts 0xDA7E afterwards.
- R9: Once high, `rst_req_o` stays high until `rst_ni` is asserted.
- R10: Writes and counting take effect only while `tim_mode_i` is 2'b10 (64-bit watchdog) and `half_run_i` is 2'b11. Otherwise state and counter hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Control word: key [31:16], enable bit 14 |
| tim_mode_i | input | 2 | Global timer mode, 2'b10 selects watchdog |
| half_run_i | input | 2 | Out-of-reset flags of the two counter halves |
| period_i | input | 64 | Expiry period in clocks |
| rst_req_o | output | 1 | Sticky system reset request |

## Verification
The bench aims at the exact expiry edge: an off-by-one counter would raise the request one clock early or late against the P+1 rule. It checks that a service with a lone second key does not clear the count, and that a wrong key between the two service keys bites; a design that skipped either would keep a runaway system alive. It also checks that invalid keys before arming are harmless and leave the pre-armed state intact, that the enable bit is sticky, and that a non-watchdog mode freezes the count mid-run rather than resetting it. Random key streams against a bench model cover the rest.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WD_IDLE = 2'd0,
    WD_PRE  = 2'd1,
    WD_ACT  = 2'd2,
    WD_SVC  = 2'd3
  } wd_state_e;

  localparam int unsigned WD_DATA_W  = 32;
  localparam int unsigned WD_KEY_W   = 16;
  localparam int unsigned WD_KEY_LSB = 16;
  localparam int unsigned WD_EN_BIT  = 14;
  localparam logic [15:0] WD_KEY_ARM = 16'hA5C6;
  localparam logic [15:0] WD_KEY_RUN = 16'hDA7E;
  localparam logic [1:0]  WD_MODE_WDOG = 2'b10;
endpackage

// File: rtl/wdog_key_decode.sv
module wdog_key_decode #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned KEY_W   = 16,
  parameter int unsigned KEY_LSB = 16,
  parameter int unsigned EN_BIT  = 14,
  parameter logic [KEY_W-1:0] KEY_ARM = 16'hA5C6,
  parameter logic [KEY_W-1:0] KEY_RUN = 16'hDA7E
) (
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              key_arm_o,
  output logic              key_run_o,
  output logic              key_bad_o,
  output logic              en_bit_o
);
  logic [KEY_W-1:0] key;

  assign key       = wr_data_i[KEY_LSB +: KEY_W];
  assign key_arm_o = (key == KEY_ARM);
  assign key_run_o = (key == KEY_RUN);
  assign key_bad_o = ~(key_arm_o | key_run_o);
  assign en_bit_o  = wr_data_i[EN_BIT];
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             over_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign over_o = (cnt_q >= period_i);
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
  import wdog_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      step_i,
  input  logic      wr_i,
  input  logic      key_arm_i,
  input  logic      key_run_i,
  input  logic      key_bad_i,
  input  logic      en_bit_i,
  input  logic      over_i,
  output wd_state_e state_o,
  output logic      en_o,
  output logic      active_o,
  output logic      clr_o,
  output logic      rst_req_o
);
  wd_state_e state_q, state_d;
  logic      en_q, req_q, bite;
  logic      wr_ok;

  assign wr_ok    = step_i & wr_i;
  assign active_o = (state_q == WD_ACT) || (state_q == WD_SVC);

  always_comb begin
    state_d = state_q;
    clr_o   = 1'b0;
    if (wr_ok) begin
      unique case (state_q)
        WD_IDLE: if (key_arm_i && (en_q || en_bit_i)) state_d = WD_PRE;
        WD_PRE:  if (key_run_i) begin state_d = WD_ACT; clr_o = 1'b1; end
        WD_ACT:  if (key_arm_i) state_d = WD_SVC;
        WD_SVC:  if (key_run_i) begin state_d = WD_ACT; clr_o = 1'b1; end
        default: state_d = WD_IDLE;
      endcase
    end
  end

  // expiry or runaway key while armed
  assign bite = step_i & active_o & (over_i | (wr_i & key_bad_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WD_IDLE;
      en_q    <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (wr_ok && en_bit_i) en_q <= 1'b1;
      if (bite) req_q <= 1'b1;
    end
  end

  assign state_o   = state_q;
  assign en_o      = en_q;
  assign rst_req_o = req_q;
endmodule

// File: rtl/wdog_key_ctrl.sv
module wdog_key_ctrl
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned DATA_W = WD_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        tim_mode_i,
  input  logic [1:0]        half_run_i,
  input  logic [CNT_W-1:0]  period_i,
  output logic              rst_req_o
);
  wd_state_e        state;
  logic             key_arm, key_run, key_bad, en_bit;
  logic             mode_ok, step, active, clr, cnt_over, en_q, req;
  logic [CNT_W-1:0] cnt;

  assign mode_ok = (tim_mode_i == WD_MODE_WDOG) && (&half_run_i);
  assign step    = mode_ok & ~req;

  wdog_key_decode #(
    .DATA_W (DATA_W),
    .KEY_W  (WD_KEY_W),
    .KEY_LSB(WD_KEY_LSB),
    .EN_BIT (WD_EN_BIT),
    .KEY_ARM(WD_KEY_ARM),
    .KEY_RUN(WD_KEY_RUN)
  ) u_dec (
    .wr_data_i(wr_data_i),
    .key_arm_o(key_arm),
    .key_run_o(key_run),
    .key_bad_o(key_bad),
    .en_bit_o (en_bit)
  );

  wdog_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step),
    .wr_i     (wr_en_i),
    .key_arm_i(key_arm),
    .key_run_i(key_run),
    .key_bad_i(key_bad),
    .en_bit_i (en_bit),
    .over_i   (cnt_over),
    .state_o  (state),
    .en_o     (en_q),
    .active_o (active),
    .clr_o    (clr),
    .rst_req_o(req)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (step & active),
    .clr_i   (clr),
    .period_i(period_i),
    .cnt_o   (cnt),
    .over_o  (cnt_over)
  );

  assign rst_req_o = req;
endmodule

// File: rtl/wdog_key_ctrl_chk.sv
module wdog_key_ctrl_chk #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [1:0]        tim_mode_i,
  input logic [1:0]        half_run_i,
  input logic [CNT_W-1:0]  period_i,
  input logic              rst_req_o,
  input logic [1:0]        state_i,
  input logic              en_i,
  input logic [CNT_W-1:0]  cnt_i
);
  logic ok, armed, bad_key;
  assign ok      = (tim_mode_i == 2'b10) && (half_run_i == 2'b11);
  assign armed   = state_i[1];
  assign bad_key = (wr_data_i[31:16] != 16'hA5C6) && (wr_data_i[31:16] != 16'hDA7E);

  p_req_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o);

  p_en_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> en_i);

  p_no_req_unarmed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> !rst_req_o);

  p_bad_key_bite_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok && armed && wr_en_i && bad_key) |=> rst_req_o);

  p_expire_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok && armed && (cnt_i >= period_i)) |=> rst_req_o);

  p_arm_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok && !rst_req_o && state_i == 2'd1 && wr_en_i && wr_data_i[31:16] == 16'hDA7E)
      |=> (state_i == 2'd2 && cnt_i == '0));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ok |=> ($stable(state_i) && $stable(cnt_i)));
endmodule

bind wdog_key_ctrl wdog_key_ctrl_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .tim_mode_i(tim_mode_i),
  .half_run_i(half_run_i),
  .period_i  (period_i),
  .rst_req_o (rst_req_o),
  .state_i   (state),
  .en_i      (en_q),
  .cnt_i     (cnt)
);

// File: tb/wdog_key_ctrl_bench.sv
`timescale 1ns/1ps
module wdog_key_ctrl_bench;
  localparam logic [15:0] K_ARM = 16'hA5C6;
  localparam logic [15:0] K_RUN = 16'hDA7E;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [1:0]  tim_mode_i = 2'b10;
  logic [1:0]  half_run_i = 2'b11;
  logic [63:0] period_i = 64'd5;
  logic        rst_req_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  wdog_key_ctrl u_wdog_key_ctrl (.*);

  // bench reference model: 0 idle, 1 pre, 2 active, 3 service pending
  int          m_st;
  bit          m_en, m_req;
  logic [63:0] m_cnt;

  function automatic bit f_ok();
    return (tim_mode_i == 2'b10) && (half_run_i == 2'b11);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_en = 0; m_req = 0; m_cnt = '0;
    end else if (f_ok() && !m_req) begin
      logic [15:0] k;
      bit act, bite, clr;
      k    = wr_data_i[31:16];
      act  = (m_st >= 2);
      bite = act && ((m_cnt >= period_i) || (wr_en_i && k != K_ARM && k != K_RUN));
      clr  = 0;
      if (wr_en_i) begin
        case (m_st)
          0: if (k == K_ARM && (m_en || wr_data_i[14])) m_st = 1;
          1: if (k == K_RUN) begin m_st = 2; clr = 1; end
          2: if (k == K_ARM) m_st = 3;
          default: if (k == K_RUN) begin m_st = 2; clr = 1; end
        endcase
        if (wr_data_i[14]) m_en = 1;
      end
      if (clr) m_cnt = '0;
      else if (act) m_cnt = m_cnt + 64'd1;
      if (bite) m_req = 1;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: rst_req_o=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; wr_en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // write lands on the next edge; returns at the negedge after it
  task automatic wr(input logic [15:0] key, input bit en);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wr_data_i = {key, 1'b0, en, 14'h0};
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic arm();
    wr(K_ARM, 1'b1);
    wr(K_RUN, 1'b0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, rst_req_o=%b expected completion", rst_req_o);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle(2);
    chk("R1 during reset", rst_req_o, 1'b0);
    rst_ni = 1'b1;
    idle(3);
    chk("R1 after reset", rst_req_o, 1'b0);

    // R5: exact expiry edge, P=5
    period_i = 64'd5;
    arm();
    idle(5);
    chk("R5 one before expiry", rst_req_o, 1'b0);
    idle(1);
    chk("R5 expiry edge", rst_req_o, 1'b1);
    idle(4);
    chk("R9 request sticky", rst_req_o, 1'b1);
    wr(16'h1234, 1'b0);
    chk("R9 sticky after write", rst_req_o, 1'b1);
    do_reset();
    chk("R1 reset clears request", rst_req_o, 1'b0);

    // R6: service restarts count; lone run key does not
    period_i = 64'd10;
    arm();
    idle(5);
    wr(K_ARM, 1'b0);
    wr(K_RUN, 1'b0);
    idle(10);
    chk("R6 service holds off", rst_req_o, 1'b0);
    idle(1);
    chk("R6 expiry after service", rst_req_o, 1'b1);
    do_reset();
    arm();
    idle(4);
    wr(K_RUN, 1'b0);
    idle(5);
    chk("R6 lone run key no clear", rst_req_o, 1'b1);

    // R7: wrong key while active, and between service keys
    do_reset();
    period_i = 64'd1000;
    arm();
    idle(3);
    chk("R7 active quiet", rst_req_o, 1'b0);
    wr(16'hBEEF, 1'b1);
    chk("R7 wrong key bites", rst_req_o, 1'b1);
    do_reset();
    arm();
    wr(K_ARM, 1'b0);
    wr(16'h0000, 1'b0);
    chk("R7 wrong key mid service", rst_req_o, 1'b1);

    // R3/R4/R8: keys without enable, out of order, invalid before active
    do_reset();
    period_i = 64'd3;
    wr(K_ARM, 1'b0);
    wr(K_RUN, 1'b0);
    idle(6);
    chk("R3 no enable stays idle", rst_req_o, 1'b0);
    wr(16'h5555, 1'b0);
    chk("R8 bad key idle ignored", rst_req_o, 1'b0);
    wr(K_RUN, 1'b1);
    idle(6);
    chk("R4 run key from idle ignored", rst_req_o, 1'b0);
    // enable now sticky from last write (R2)
    wr(K_ARM, 1'b0);
    wr(16'h7777, 1'b0);
    chk("R8 bad key pre-armed ignored", rst_req_o, 1'b0);
    wr(K_RUN, 1'b0);
    idle(3);
    chk("R2 R4 armed via sticky enable", rst_req_o, 1'b0);
    idle(1);
    chk("R2 R4 expiry after sticky arm", rst_req_o, 1'b1);

    // R10: mode gating freezes count and writes
    do_reset();
    period_i = 64'd4;
    tim_mode_i = 2'b01;
    arm();
    tim_mode_i = 2'b10;
    wr(16'hDEAD, 1'b0);
    chk("R10 writes ignored off-mode", rst_req_o, 1'b0);
    arm();
    idle(2);
    half_run_i = 2'b01;
    idle(10);
    chk("R10 count held off-mode", rst_req_o, 1'b0);
    half_run_i = 2'b11;
    idle(2);
    chk("R10 resumed not yet", rst_req_o, 1'b0);
    idle(1);
    chk("R10 resumed expiry", rst_req_o, 1'b1);

    // random episodes against the model
    for (int ep = 0; ep < 40; ep++) begin
      do_reset();
      period_i = 64'($urandom_range(0, 40));
      for (int c = 0; c < 200; c++) begin
        @(negedge clk_i);
        chk("R3 R5 R6 R7 R10 random model", rst_req_o, m_req);
        wr_en_i = ($urandom_range(0, 3) == 0);
        case ($urandom_range(0, 4))
          0, 1: wr_data_i[31:16] = K_ARM;
          2, 3: wr_data_i[31:16] = K_RUN;
          default: wr_data_i[31:16] = 16'($urandom);
        endcase
        wr_data_i[15:0] = 16'($urandom);
        tim_mode_i = ($urandom_range(0, 9) == 0) ? 2'b11 : 2'b10;
        half_run_i = ($urandom_range(0, 19) == 0) ? 2'b10 : 2'b11;
      end
      wr_en_i = 1'b0;
      tim_mode_i = 2'b10;
      half_run_i = 2'b11;
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule